// File: doc/BRIEF.md
# Colour Palette Loader and Lookup

This block sits between a word-stream source (a DMA engine feeding 16-bit words over a valid/ready handshake) and a display pipeline. When the controller is enabled it starts a load session whose behaviour follows a 2-bit load-mode input. In a palette session, the first word carries a pixel-depth code in its top nibble and the colour of entry 0 in its low twelve bits. Each following word carries one more 12-bit RGB entry. The block works out from the depth code how many words belong to the palette and stores exactly that many.

After the palette is in, the block raises a palette-loaded flag, with an optional interrupt. It then either drops further words or forwards them unchanged to a downstream stream port, as frame data. A separate pixel port turns pixel indices into colours, one cycle later. The index is cut down to the width that the stored depth code implies. An illegal depth code raises an error flag and stops the load.

Top module: `pal_stream_loader`

## Requirements
- R1: During and right after reset, s_ready, m_valid, pal_loaded, pal_irq, hdr_err and col_valid are all 0, and the stored depth code is 3 (8 bpp).
- R2: In the first enabled cycle no word is accepted, and ctrl_mode is captured for the session: 2'b01 loads the palette only, 2'b10 passes frame data only, 2'b00 loads the palette and then passes frame data, and 2'b11 accepts every word and discards it.
- R3: In palette word 0, bits [15:12] hold the depth code and bits [11:0] hold entry 0. The codes are 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp, 3 = 8 bpp and 4 = 12/16 bpp.
- R4: Codes 0 to 3 load 256 entries and code 4 loads 16. Word k writes entry k, with red in [11:8], green in [7:4] and blue in [3:0].
- R5: pal_loaded goes to 1 in the cycle after the last palette word is accepted. pal_irq equals pal_loaded AND irq_en.
- R6: In a palette-only session, words that arrive after the palette is complete are accepted and dropped. They raise no m_valid and do not change the table.
- R7: During the frame phase, m_valid = s_valid, m_data = s_data and s_ready = m_ready, all in the same cycle.
- R8: flag_clr clears pal_loaded only in a palette-only session and is ignored in any other session. Deasserting ctrl_enable clears pal_loaded and hdr_err on the next edge.
- R9: A depth code of 5 to 15 sets hdr_err and ends the load. The table and the stored depth code are left unchanged, later words are dropped, and pal_loaded stays 0.
- R10: col_valid follows pix_valid one cycle later, and col_rgb holds the entry addressed by pix_index masked to the low 1, 2, 4, 8 or 4 bits for depth codes 0, 1, 2, 3 or 4. A read in the same cycle as a write to that entry returns the old value.
- R11: While ctrl_enable is 0, s_ready is 0 and m_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_enable | input | 1 | Controller enable; a rising level starts a session |
| ctrl_mode | input | 2 | Load-mode field |
| irq_en | input | 1 | Enable for the palette-loaded interrupt |
| flag_clr | input | 1 | Software clear of the loaded flag |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Input word ready |
| s_data | input | 16 | Input word |
| m_valid | output | 1 | Forwarded frame word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 16 | Forwarded frame word |
| pix_valid | input | 1 | Lookup request |
| pix_index | input | 8 | Pixel index |
| col_valid | output | 1 | Lookup result valid |
| col_rgb | output | 12 | Looked-up colour |
| pal_loaded | output | 1 | Palette-loaded flag |
| pal_irq | output | 1 | Gated palette-loaded interrupt |
| hdr_err | output | 1 | Illegal depth code seen |

## Verification
The hardest case to reach from the ports is the boundary at the end of a load, where three things happen at once. The last palette word is accepted, the flag rises, and the next word is dropped or forwarded depending on the session mode. Random gaps in s_valid, random backpressure on m_ready and random lookups shift that boundary to different cycles.

The bench runs full 256-word loads for several depth codes and a short 16-word load. It also sends an illegal header after a valid palette, to show that the stored table and depth survive the failed load. Lookups keep running while loads are in progress, which exercises the read-before-write rule.

// File: rtl/pal_pkg.sv
// Package: shared state and load-mode encodings for the palette loader.
// Assumes: load-mode values are fixed by the control field layout.
package pal_pkg;

    typedef enum logic [1:0] {
        LM_BOTH  = 2'b00,
        LM_PAL   = 2'b01,
        LM_FRAME = 2'b10,
        LM_NONE  = 2'b11
    } load_mode_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_PAL,
        PS_FRAME,
        PS_DRAIN,
        PS_HALT
    } pal_state_e;

    localparam int unsigned CODE_W    = 4;
    localparam int unsigned CODE_MAXOK = 4;

endpackage

// File: rtl/pal_hdr_decode.sv
// Module: pal_hdr_decode
// Turns a depth code into its legality, the number of palette entries it
// implies and the index mask used for lookup.
// Assumes: IDX_W >= 4 and SMALL_ENTRIES is a power of two <= 2**IDX_W.
module pal_hdr_decode #(
    parameter int unsigned IDX_W         = 8,
    parameter int unsigned SMALL_ENTRIES = 16,
    parameter int unsigned CNT_W         = 9
) (
    input  logic [pal_pkg::CODE_W-1:0] code,
    output logic                       code_ok,
    output logic [CNT_W-1:0]           entry_cnt,
    output logic [IDX_W-1:0]           idx_mask
);
    localparam int unsigned FULL_ENTRIES = 1 << IDX_W;
    localparam int unsigned SMALL_BITS   = $clog2(SMALL_ENTRIES);
    localparam int unsigned BW           = $clog2(IDX_W + 1);

    logic [BW-1:0]  bits;
    logic [IDX_W:0] span;

    // Map the depth code to index width and palette length.
    always_comb begin
        code_ok   = 1'b1;
        entry_cnt = CNT_W'(FULL_ENTRIES);
        case (code)
            4'd0:    bits = BW'(1);
            4'd1:    bits = BW'(2);
            4'd2:    bits = BW'(4);
            4'd3:    bits = BW'(IDX_W);
            4'd4: begin
                bits      = BW'(SMALL_BITS);
                entry_cnt = CNT_W'(SMALL_ENTRIES);
            end
            default: begin
                bits    = BW'(IDX_W);
                code_ok = 1'b0;
            end
        endcase
        span     = ((IDX_W + 1)'(1) << bits) - (IDX_W + 1)'(1);
        idx_mask = span[IDX_W-1:0];
    end

endmodule

// File: rtl/pal_table.sv
// Module: pal_table
// Colour storage with one write port and one registered read port.
// Assumes: a read and a write of the same entry in one cycle returns the
// old contents; the table is cleared by reset.
module pal_table #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic               rd_valid,
    output logic [ENTRY_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Storage: cleared on reset, written by the loader.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Registered read port: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[rd_addr];
        end
    end

    a_r10_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

endmodule

// File: rtl/pal_load_fsm.sv
// Module: pal_load_fsm
// Session sequencer: captures the load mode, counts palette words, drives
// the table write port, and keeps the loaded flag, error flag and depth code.
// Assumes: acc is the accepted-word strobe formed at the top level.
module pal_load_fsm
    import pal_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ENTRY_W = 12,
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned CNT_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         mode,
    input  logic               flag_clr,
    input  logic               acc,
    input  logic [DATA_W-1:0]  word,
    input  logic               hdr_ok,
    input  logic [CNT_W-1:0]   hdr_cnt,
    output pal_state_e         state,
    output logic               loaded,
    output logic               err,
    output logic [CODE_W-1:0]  depth_code,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_addr,
    output logic [ENTRY_W-1:0] wr_data
);
    load_mode_e       mode_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] need;
    logic             is_hdr;
    logic             last_word;
    logic             set_loaded;

    // Decode the current word's role in the palette.
    always_comb begin
        is_hdr     = (cnt == '0);
        last_word  = !is_hdr && (cnt == need - CNT_W'(1));
        wr_en      = (state == PS_PAL) && acc && (!is_hdr || hdr_ok);
        wr_addr    = cnt[IDX_W-1:0];
        wr_data    = word[ENTRY_W-1:0];
        set_loaded = (state == PS_PAL) && acc && last_word;
    end

    // Session state, word counter and captured mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PS_IDLE;
            mode_q <= LM_BOTH;
            cnt    <= '0;
            need   <= '0;
        end else if (!enable) begin
            state <= PS_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                PS_IDLE: begin
                    mode_q <= load_mode_e'(mode);
                    cnt    <= '0;
                    case (load_mode_e'(mode))
                        LM_FRAME: state <= PS_FRAME;
                        LM_NONE:  state <= PS_DRAIN;
                        default:  state <= PS_PAL;
                    endcase
                end
                PS_PAL: begin
                    if (acc) begin
                        if (is_hdr) begin
                            if (!hdr_ok) begin
                                state <= PS_HALT;
                            end else begin
                                need <= hdr_cnt;
                                cnt  <= CNT_W'(1);
                            end
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                            if (last_word)
                                state <= (mode_q == LM_BOTH) ? PS_FRAME : PS_DRAIN;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Depth code kept from the last legal header.
    always_ff @(posedge clk) begin
        if (!rst_n)
            depth_code <= CODE_W'(3);
        else if (enable && state == PS_PAL && acc && is_hdr && hdr_ok)
            depth_code <= word[DATA_W-1 -: CODE_W];
    end

    // Loaded and error flags with their set and clear rules.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            loaded <= 1'b0;
            err    <= 1'b0;
        end else begin
            if (set_loaded)
                loaded <= 1'b1;
            else if (flag_clr && mode_q == LM_PAL)
                loaded <= 1'b0;
            if (state == PS_PAL && acc && is_hdr && !hdr_ok)
                err <= 1'b1;
        end
    end

    a_r5_loaded_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loaded) |-> $past(acc));
    a_r8_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!loaded && !err));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && enable) |=> (err && !loaded));

endmodule

// File: rtl/pal_stream_loader.sv
// Module: pal_stream_loader (top)
// Joins the word stream to the loader, the forwarding path and the lookup
// table, and masks pixel indices to the stored depth.
// Assumes: the forwarding path is combinational (no added latency).
module pal_stream_loader
    import pal_pkg::*;
#(
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned ENTRY_W       = 12,
    parameter int unsigned IDX_W         = 8,
    parameter int unsigned SMALL_ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_enable,
    input  logic [1:0]         ctrl_mode,
    input  logic               irq_en,
    input  logic               flag_clr,
    input  logic               s_valid,
    output logic               s_ready,
    input  logic [DATA_W-1:0]  s_data,
    output logic               m_valid,
    input  logic               m_ready,
    output logic [DATA_W-1:0]  m_data,
    input  logic               pix_valid,
    input  logic [IDX_W-1:0]   pix_index,
    output logic               col_valid,
    output logic [ENTRY_W-1:0] col_rgb,
    output logic               pal_loaded,
    output logic               pal_irq,
    output logic               hdr_err
);
    localparam int unsigned CNT_W = $clog2((1 << IDX_W) + 1);

    pal_state_e         st;
    logic               acc;
    logic               hdr_ok;
    logic [CNT_W-1:0]   hdr_cnt;
    logic [IDX_W-1:0]   hdr_mask_unused;
    logic [CODE_W-1:0]  depth_code;
    logic               cur_ok_unused;
    logic [CNT_W-1:0]   cur_cnt_unused;
    logic [IDX_W-1:0]   cur_mask;
    logic               tbl_wr;
    logic [IDX_W-1:0]   tbl_waddr;
    logic [ENTRY_W-1:0] tbl_wdata;

    // Handshake and forwarding for the input stream.
    always_comb begin
        if (!ctrl_enable)
            s_ready = 1'b0;
        else if (st == PS_FRAME)
            s_ready = m_ready;
        else
            s_ready = (st != PS_IDLE);
        m_valid = ctrl_enable && (st == PS_FRAME) && s_valid;
        m_data  = s_data;
        acc     = s_valid && s_ready;
        pal_irq = pal_loaded && irq_en;
    end

    pal_hdr_decode #(.IDX_W(IDX_W), .SMALL_ENTRIES(SMALL_ENTRIES), .CNT_W(CNT_W)) u_hdr (
        .code      (s_data[DATA_W-1 -: CODE_W]),
        .code_ok   (hdr_ok),
        .entry_cnt (hdr_cnt),
        .idx_mask  (hdr_mask_unused)
    );

    pal_hdr_decode #(.IDX_W(IDX_W), .SMALL_ENTRIES(SMALL_ENTRIES), .CNT_W(CNT_W)) u_cur (
        .code      (depth_code),
        .code_ok   (cur_ok_unused),
        .entry_cnt (cur_cnt_unused),
        .idx_mask  (cur_mask)
    );

    pal_load_fsm #(.DATA_W(DATA_W), .ENTRY_W(ENTRY_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctrl_enable),
        .mode       (ctrl_mode),
        .flag_clr   (flag_clr),
        .acc        (acc),
        .word       (s_data),
        .hdr_ok     (hdr_ok),
        .hdr_cnt    (hdr_cnt),
        .state      (st),
        .loaded     (pal_loaded),
        .err        (hdr_err),
        .depth_code (depth_code),
        .wr_en      (tbl_wr),
        .wr_addr    (tbl_waddr),
        .wr_data    (tbl_wdata)
    );

    pal_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr),
        .wr_addr  (tbl_waddr),
        .wr_data  (tbl_wdata),
        .rd_en    (pix_valid),
        .rd_addr  (pix_index & cur_mask),
        .rd_valid (col_valid),
        .rd_data  (col_rgb)
    );

    a_r11_idle_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_enable |-> (!s_ready && !m_valid));
    a_r6_drain_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_DRAIN) |-> !tbl_wr);
    a_r7_forward_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> !tbl_wr);
    a_r9_err_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |-> !m_valid);

endmodule

// File: tb/pal_stream_loader_tb.sv
// Bench: behavioural reference model compared against the design every cycle,
// plus directed checks at the corner cases.
module pal_stream_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_enable = 1'b0;
    logic [1:0]  ctrl_mode = 2'b00;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_data = '0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [15:0] m_data;
    logic        pix_valid = 1'b0;
    logic [7:0]  pix_index = '0;
    logic        col_valid;
    logic [11:0] col_rgb;
    logic        pal_loaded;
    logic        pal_irq;
    logic        hdr_err;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit cmp_on = 0;
    bit pix_rand = 1;
    bit acc_seen = 0;

    // reference model state
    int          ph = 0;        // 0 idle,1 palette,2 frame,3 drop,4 halted
    int          wcnt = 0;
    int          need = 0;
    int          mode_l = 0;
    int          depth = 3;
    bit          m_loaded = 0;
    bit          m_err = 0;
    bit          m_colv = 0;
    logic [11:0] m_col = '0;
    logic [11:0] pal [256];

    always #4 clk = ~clk;

    pal_stream_loader u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .ctrl_mode(ctrl_mode),
        .irq_en(irq_en), .flag_clr(flag_clr), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .pix_valid(pix_valid), .pix_index(pix_index), .col_valid(col_valid),
        .col_rgb(col_rgb), .pal_loaded(pal_loaded), .pal_irq(pal_irq), .hdr_err(hdr_err)
    );

    function automatic int idx_mask(input int code);
        case (code)
            0: return 1;
            1: return 3;
            2: return 15;
            4: return 15;
            default: return 255;
        endcase
    endfunction

    function automatic bit exp_ready();
        if (!ctrl_enable || ph == 0) return 0;
        if (ph == 2) return m_ready;
        return 1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h exp %0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // Reference model: advances on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        cyc++;
        acc_seen = 0;
        if (!rst_n) begin
            ph = 0; wcnt = 0; need = 0; mode_l = 0; depth = 3;
            m_loaded = 0; m_err = 0; m_colv = 0; m_col = '0;
            for (int i = 0; i < 256; i++) pal[i] = '0;
        end else begin
            bit acc;
            bit set;
            acc = s_valid && exp_ready();
            acc_seen = acc;
            set = 0;
            m_colv = pix_valid;
            if (pix_valid) m_col = pal[int'(pix_index) & idx_mask(depth)];
            if (!ctrl_enable) begin
                ph = 0; wcnt = 0; m_loaded = 0; m_err = 0;
            end else begin
                case (ph)
                    0: begin
                        mode_l = int'(ctrl_mode);
                        wcnt = 0;
                        ph = (ctrl_mode == 2'b10) ? 2 : (ctrl_mode == 2'b11) ? 3 : 1;
                    end
                    1: if (acc) begin
                        if (wcnt == 0) begin
                            if (int'(s_data[15:12]) > 4) begin
                                m_err = 1; ph = 4;
                            end else begin
                                depth = int'(s_data[15:12]);
                                need = (depth == 4) ? 16 : 256;
                                pal[0] = s_data[11:0];
                                wcnt = 1;
                            end
                        end else begin
                            pal[wcnt] = s_data[11:0];
                            wcnt++;
                            if (wcnt == need) begin
                                m_loaded = 1; set = 1;
                                ph = (mode_l == 0) ? 2 : 3;
                            end
                        end
                    end
                    default: ;
                endcase
                if (!set && flag_clr && mode_l == 1) m_loaded = 0;
            end
        end
    end

    // Per-cycle comparison, sampled well away from the clock edge.
    always @(negedge clk) begin
        #3;
        if (cmp_on) begin
            chk("R11/R7 s_ready", 32'(s_ready), 32'(exp_ready()));
            chk("R7 m_valid", 32'(m_valid), 32'(ctrl_enable && ph == 2 && s_valid));
            if (m_valid) chk("R7 m_data", 32'(m_data), 32'(s_data));
            chk("R5 pal_loaded", 32'(pal_loaded), 32'(m_loaded));
            chk("R5 pal_irq", 32'(pal_irq), 32'(m_loaded && irq_en));
            chk("R9 hdr_err", 32'(hdr_err), 32'(m_err));
            chk("R10 col_valid", 32'(col_valid), 32'(m_colv));
            if (m_colv) chk("R10 col_rgb", 32'(col_rgb), 32'(m_col));
        end
    end

    // Random lookup traffic and downstream backpressure.
    always @(negedge clk) begin
        if (pix_rand) begin
            pix_valid <= ($urandom % 3) != 0;
            pix_index <= 8'($urandom);
        end
        m_ready <= ($urandom % 2) == 0;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send_word(input logic [15:0] w);
        @(negedge clk);
        if ($urandom % 4 == 0) begin
            s_valid = 1'b0;
            @(negedge clk);
        end
        s_valid = 1'b1;
        s_data  = w;
        forever begin
            @(posedge clk);
            #1;
            if (acc_seen) break;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        s_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [11:0] ent(input int i, input int base);
        return 12'((i * 37 + base) & 12'hfff);
    endfunction

    task automatic load_pal(input int code, input int n, input int base);
        send_word({4'(code), ent(0, base)});
        for (int i = 1; i < n; i++) send_word({4'(code), ent(i, base)});
    endtask

    task automatic start(input logic [1:0] md);
        @(negedge clk);
        ctrl_mode   = md;
        ctrl_enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic stop();
        @(negedge clk);
        s_valid     = 1'b0;
        ctrl_enable = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        #3;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #3;
        chk("R1 s_ready", 32'(s_ready), 0);
        chk("R1 m_valid", 32'(m_valid), 0);
        chk("R1 pal_loaded", 32'(pal_loaded), 0);
        chk("R1 hdr_err", 32'(hdr_err), 0);
        chk("R1 col_valid", 32'(col_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        irq_en = 1'b1;

        // R2 R3 R4 R6: palette-only session, 8 bpp, then extra words dropped
        start(2'b01);
        load_pal(3, 256, 5);
        for (int i = 0; i < 6; i++) send_word(16'hABCD);
        idle(3);
        #3;
        chk("R5 loaded after load", 32'(pal_loaded), 1);
        chk("R5 irq after load", 32'(pal_irq), 1);
        chk("R6 no forward in drain", 32'(m_valid), 0);
        pulse_clr();
        chk("R8 clear in palette-only", 32'(pal_loaded), 0);
        idle(20);

        // R8: disable then palette+frame at 12/16 bpp; clear ignored
        stop();
        #3;
        chk("R8 disable clears flag", 32'(pal_loaded), 0);
        start(2'b00);
        load_pal(4, 16, 100);
        idle(2);
        pulse_clr();
        chk("R8 clear ignored outside palette-only", 32'(pal_loaded), 1);
        for (int i = 0; i < 30; i++) send_word(16'(i * 513 + 7));
        idle(10);

        // R10: directed masked lookup at 4-bit index width
        pix_rand = 0;
        @(negedge clk);
        pix_valid = 1'b1;
        pix_index = 8'h35;
        @(negedge clk);
        pix_valid = 1'b0;
        #3;
        chk("R10 masked lookup code 4", 32'(col_rgb), 32'(ent(5, 100)));
        pix_rand = 1;

        // R9: illegal depth code after a good palette
        stop();
        start(2'b01);
        send_word(16'h9FFF);
        for (int i = 0; i < 10; i++) send_word(16'h1234);
        idle(3);
        #3;
        chk("R9 err set", 32'(hdr_err), 1);
        chk("R9 no loaded", 32'(pal_loaded), 0);
        idle(20);

        // R2: frame-only session
        stop();
        start(2'b10);
        for (int i = 0; i < 20; i++) send_word(16'(i * 91 + 3));
        idle(3);

        // R2: mode 11 drops everything
        stop();
        start(2'b11);
        for (int i = 0; i < 10; i++) send_word(16'h4321);
        idle(3);
        #3;
        chk("R2 mode 11 no flag", 32'(pal_loaded), 0);

        // R3 R4 R10: 1, 2 and 4 bpp palettes
        for (int c = 0; c < 3; c++) begin
            stop();
            start(2'b01);
            load_pal(c, 256, 200 + c);
            idle(30);
        end
        pix_rand = 0;
        @(negedge clk);
        pix_valid = 1'b1;
        pix_index = 8'hFE;
        @(negedge clk);
        pix_valid = 1'b0;
        #3;
        chk("R10 masked lookup code 2", 32'(col_rgb), 32'(ent(14, 202)));
        pix_rand = 1;
        idle(5);

        stop();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule